// File: doc/BRIEF.md
# Serial Command and Data Register Port

This block is the host-facing serial port of a converter-style device. A host drives a chip-select, a serial clock and a data-in line, and reads back over a data-out line. Every access is one 32-clock frame: an 8-bit command followed by a 24-bit data word, most significant bit first. A write frame loads one of eight 24-bit registers. A read frame shifts a register back out. Register 0 is the control word. It holds a run bit and the conversion period.

While running, a conversion timer finishes a conversion once per period, counted in system clock cycles. The first conversion after the run bit is set takes seven extra cycles. Each finished conversion captures the 24-bit converter sample. While chip select is low and the port is between frames, the pending result shows as a low level on data out. A frame that starts while a result is pending is a result readout. Its first 8 clocks only clear the flag, and its last 24 clocks carry the result. A result that finishes during a readout is held back and presented once that readout is over.

All serial inputs are oversampled in the system clock domain. The host must keep each serial clock level for at least three system clock cycles.

Top module: `serial_cmd_port`

## Requirements
- R1: The data-out enable `sdo_oe_o` is low whenever the synchronised chip select is high. It follows `csn_i` two clock edges after the edge that samples it, and it is low during reset.
- R2: Serial clock and data-in activity while chip select is high changes no register and starts no frame.
- R3: A frame is 8 command bits and then 24 data bits, most significant bit first. Data in is sampled on serial clock rising edges, and data out changes on falling edges. Command bit 7 set means read and clear means write. Bits 2:0 give the register number.
- R4: A write frame stores its 24 data bits in the addressed register. A read frame returns that register's value during its 24 data clocks. Register 0 is control: bit 23 is run, and bits 15:0 are the conversion period. Its reset value is run clear with the period equal to `DEFAULT_RATIO`.
- R5: A command with any of bits 6:3 set writes nothing, and a read with such a command returns all zeros.
- R6: Raising chip select before the 32nd rising edge aborts the frame. The bit count returns to zero and no register is written.
- R7: After run is set, the first conversion completes period+7 cycles later, and each later one completes after another period. The result is `conv_data_i` as sampled at completion, so successive results differ by a multiple of the period.
- R8: While chip select is low between frames and a result is pending, data out is driven low. A frame started in that state is a readout: its 8 command clocks ignore data in and clear the flag, and its 24 data clocks shift out the result, MSB first.
- R9: A conversion that completes during a readout does not disturb it. Its result is held and raises the flag as soon as the readout ends.
- R10: With chip select held low throughout, frames may follow one another back to back (three-wire use).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the conversion time base |
| rst | input | 1 | Synchronous active-high reset |
| csn_i | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data from the host |
| conv_data_i | input | DATA_W | Converter sample captured at each conversion completion |
| sdo_o | output | 1 | Serial data to the host |
| sdo_oe_o | output | 1 | Output enable for data out; low means high impedance |

## Verification
The bench builds the port with a 24-bit word, a 16-bit period field, a reset period of 100 and two synchroniser stages. It then writes a period of 40. With that period, the 64-cycle clear phase and the 256-cycle readout each contain at least one conversion completion, which exercises the hold path. The seven-cycle first-conversion offset can also be told apart from the period. The converter input is driven with the bench's cycle count, so every captured result shows the exact cycle in which it was taken.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int CMD_W    = 8;
  localparam int ADDR_W   = 3;
  localparam int NUM_REGS = 8;

  typedef struct packed {
    logic              rd;
    logic [3:0]        rsv;
    logic [ADDR_W-1:0] addr;
  } cmd_t;
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) st[g] <= rst ? RST_VAL : d;
    end else begin : g_next
      always_ff @(posedge clk) st[g] <= rst ? RST_VAL : st[g-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/scp_regfile.sv
module scp_regfile import scp_pkg::*; #(
  parameter int DATA_W        = 24,
  parameter int RATIO_W       = 16,
  parameter int DEFAULT_RATIO = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata,
  output logic              run_o,
  output logic [RATIO_W-1:0] ratio_o
);
  localparam logic [DATA_W-1:0] CTRL_RST = DATA_W'(DEFAULT_RATIO);

  logic [DATA_W-1:0] mem [NUM_REGS];
  logic [DATA_W-1:0] ctrl;

  // Entries 1..7 live in a plain array so it can map onto block RAM.
  always_ff @(posedge clk) begin
    if (wr_en && waddr != '0) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)                        ctrl <= CTRL_RST;
    else if (wr_en && waddr == '0)  ctrl <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= (raddr == '0) ? ctrl : mem[raddr];
  end

  assign run_o   = ctrl[DATA_W-1];
  assign ratio_o = ctrl[RATIO_W-1:0];
endmodule

// File: rtl/scp_conv.sv
module scp_conv #(
  parameter int DATA_W      = 24,
  parameter int RATIO_W     = 16,
  parameter int FIRST_EXTRA = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic [RATIO_W-1:0] ratio,
  input  logic [DATA_W-1:0]  conv_data,
  input  logic               clr,
  input  logic               busy,
  output logic               flag,
  output logic [DATA_W-1:0]  result
);
  localparam int EW = RATIO_W + 1;

  logic [EW-1:0]     elapsed;
  logic              first;
  logic [EW-1:0]     target;
  logic              done;
  logic [DATA_W-1:0] hold;
  logic              hold_v;

  always_comb begin
    target = (ratio == '0) ? EW'(1) : EW'(ratio);
    if (first) target = target + EW'(FIRST_EXTRA);
  end

  assign done = run && (elapsed == target - EW'(1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      elapsed <= '0;
      first   <= 1'b1;
    end else if (done) begin
      elapsed <= '0;
      first   <= 1'b0;
    end else begin
      elapsed <= elapsed + EW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag   <= 1'b0;
      hold_v <= 1'b0;
      result <= '0;
      hold   <= '0;
    end else begin
      if (clr) flag <= 1'b0;
      if (done) begin
        if (busy) begin
          hold   <= conv_data;
          hold_v <= 1'b1;
        end else begin
          result <= conv_data;
          flag   <= 1'b1;
        end
      end else if (hold_v && !busy) begin
        result <= hold;
        flag   <= 1'b1;
        hold_v <= 1'b0;
      end
    end
  end

  p_clear_flag_r8: assert property (@(posedge clk) disable iff (rst)
    clr |=> !flag);
  p_hold_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (done && busy) |=> hold_v);
  p_release_r9: assert property (@(posedge clk) disable iff (rst)
    (hold_v && !busy) |=> flag);
endmodule

// File: rtl/scp_frame.sv
module scp_frame import scp_pkg::*; #(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  logic              rise,
  input  logic              fall,
  input  logic              sdi,
  input  logic              flag_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] raddr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] waddr,
  output logic [DATA_W-1:0] wdata,
  output logic              clr_o,
  output logic              busy_o,
  output logic              sdo_o
);
  localparam int FRAME_LEN = CMD_W + DATA_W;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] CMD_END = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(FRAME_LEN - 1);

  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] sh_in;
  logic [DATA_W-1:0] out_sh;
  cmd_t              cmd_q;
  cmd_t              cmd_now;
  logic              res_frame;
  logic              data_phase;
  logic              load_pend;
  logic              sdo_q;

  assign cmd_now = cmd_t'({sh_in[CMD_W-2:0], sdi});
  assign raddr   = cmd_now.addr;
  assign busy_o  = res_frame;
  assign sdo_o   = sdo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      sh_in      <= '0;
      out_sh     <= '0;
      cmd_q      <= '0;
      res_frame  <= 1'b0;
      data_phase <= 1'b0;
      load_pend  <= 1'b0;
      wr_en      <= 1'b0;
      waddr      <= '0;
      wdata      <= '0;
      clr_o      <= 1'b0;
      sdo_q      <= 1'b1;
    end else begin
      wr_en     <= 1'b0;
      clr_o     <= 1'b0;
      load_pend <= 1'b0;
      if (!cs_act) begin
        cnt        <= '0;
        res_frame  <= 1'b0;
        data_phase <= 1'b0;
        sdo_q      <= !flag_i;
      end else begin
        if (load_pend) out_sh <= (cmd_q.rsv == '0) ? rdata_i : '0;
        if (rise) begin
          sh_in <= {sh_in[DATA_W-2:0], sdi};
          if (cnt == '0) res_frame <= flag_i;
          if (cnt == CMD_END) begin
            cmd_q      <= cmd_now;
            data_phase <= 1'b1;
            if (res_frame) begin
              clr_o  <= 1'b1;
              out_sh <= result_i;
            end else if (cmd_now.rd) begin
              load_pend <= 1'b1;
            end else begin
              out_sh <= '0;
            end
          end
          if (cnt == LAST) begin
            cnt        <= '0;
            data_phase <= 1'b0;
            res_frame  <= 1'b0;
            if (!res_frame && !cmd_q.rd && cmd_q.rsv == '0) begin
              wr_en <= 1'b1;
              waddr <= cmd_q.addr;
              wdata <= {sh_in[DATA_W-2:0], sdi};
            end
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        if (fall && data_phase) begin
          sdo_q  <= out_sh[DATA_W-1];
          out_sh <= {out_sh[DATA_W-2:0], 1'b0};
        end else if (!data_phase) begin
          sdo_q <= !flag_i;
        end
      end
    end
  end

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  p_abort_r6: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> (cnt == '0 && !wr_en));
  p_clear_in_readout_r8: assert property (@(posedge clk) disable iff (rst)
    clr_o |-> busy_o);
endmodule

// File: rtl/serial_cmd_port.sv
module serial_cmd_port import scp_pkg::*; #(
  parameter int DATA_W        = 24,
  parameter int RATIO_W       = 16,
  parameter int DEFAULT_RATIO = 100,
  parameter int SYNC_STAGES   = 2,
  parameter int FIRST_EXTRA   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csn_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic [DATA_W-1:0] conv_data_i,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  logic [2:0]         synced;
  logic               s_csn, s_sclk, s_sdi;
  logic               sclk_q;
  logic               cs_act, rise, fall;
  logic [ADDR_W-1:0]  raddr, waddr;
  logic               wr_en, clr, busy, flag, run;
  logic [DATA_W-1:0]  wdata, rdata, result;
  logic [RATIO_W-1:0] ratio;

  scp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .d({csn_i, sclk_i, sdi_i}), .q(synced));

  assign {s_csn, s_sclk, s_sdi} = synced;
  assign cs_act = !s_csn;
  assign rise   = cs_act && s_sclk && !sclk_q;
  assign fall   = cs_act && !s_sclk && sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q   <= 1'b0;
      sdo_oe_o <= 1'b0;
    end else begin
      sclk_q   <= s_sclk;
      sdo_oe_o <= cs_act;
    end
  end

  scp_frame #(.DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst(rst), .cs_act(cs_act), .rise(rise), .fall(fall),
    .sdi(s_sdi), .flag_i(flag), .result_i(result), .rdata_i(rdata),
    .raddr(raddr), .wr_en(wr_en), .waddr(waddr), .wdata(wdata),
    .clr_o(clr), .busy_o(busy), .sdo_o(sdo_o));

  scp_regfile #(.DATA_W(DATA_W), .RATIO_W(RATIO_W),
                .DEFAULT_RATIO(DEFAULT_RATIO)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(rdata), .run_o(run), .ratio_o(ratio));

  scp_conv #(.DATA_W(DATA_W), .RATIO_W(RATIO_W),
             .FIRST_EXTRA(FIRST_EXTRA)) u_conv (
    .clk(clk), .rst(rst), .run(run), .ratio(ratio), .conv_data(conv_data_i),
    .clr(clr), .busy(busy), .flag(flag), .result(result));

  p_hiz_r1: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !sdo_oe_o);
endmodule

// File: tb/sim_serial_cmd_port.sv
module sim_serial_cmd_port;
  localparam int CLK_P = 10;
  localparam int HP    = 4;
  localparam int RATIO = 40;
  localparam int DEF_R = 100;

  logic clk = 1'b0, rst = 1'b1, csn = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, oe;
  logic [23:0] conv_data;
  int cyc = 0;
  int n_cmp = 0, n_bad = 0;
  bit chk_oe = 0;
  int last_rise = 0;
  logic h0 = 1'b1, h1 = 1'b1, h2 = 1'b1;
  int exp_reg [8];

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    h0 <= csn; h1 <= h0; h2 <= h1;
  end
  assign conv_data = 24'(cyc);

  serial_cmd_port #(.DATA_W(24), .RATIO_W(16), .DEFAULT_RATIO(DEF_R),
                    .SYNC_STAGES(2), .FIRST_EXTRA(7)) u0 (
    .clk(clk), .rst(rst), .csn_i(csn), .sclk_i(sclk), .sdi_i(sdi),
    .conv_data_i(conv_data), .sdo_o(sdo), .sdo_oe_o(oe));

  // R1: enable model, checked every clock
  always @(negedge clk) begin
    if (chk_oe) begin
      n_cmp++;
      if (oe !== !h2) begin
        n_bad++;
        $display("FAIL R1 enable actual=%b expected=%b", oe, !h2);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] cmd, input logic [23:0] data,
                      input bit keep, output logic [23:0] rx, output logic first);
    if (csn) begin csn = 1'b0; wclk(4); end
    first = sdo;
    rx = '0;
    for (int i = 0; i < 32; i++) begin
      sdi = (i < 8) ? cmd[7-i] : data[31-i];
      wclk(HP);
      if (i >= 8) rx[31-i] = sdo;
      sclk = 1'b1;
      last_rise = cyc;
      wclk(HP);
      sclk = 1'b0;
    end
    wclk(HP);
    if (!keep) begin csn = 1'b1; wclk(4); end
  endtask

  task automatic partial(input logic [7:0] cmd, input logic [23:0] data, input int nbits);
    csn = 1'b0; wclk(4);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 8) ? cmd[7-i] : data[31-i];
      wclk(HP); sclk = 1'b1; wclk(HP); sclk = 1'b0;
    end
    wclk(HP); csn = 1'b1; wclk(4);
  endtask

  initial begin
    #(CLK_P * 190000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [23:0] rx, r1v, r2v;
    logic f;
    int t, diff;
    wclk(5); rst = 1'b0; wclk(1); chk_oe = 1;
    check("R1 reset enable", int'(oe), 0);

    xfer(8'h80, '0, 0, rx, f);
    check("R4 reset control", int'(rx), DEF_R);
    check("R8 no flag idle", int'(f), 1);

    exp_reg[1] = 24'h123456; exp_reg[2] = 24'hFEDCBA; exp_reg[3] = 24'h800001;
    for (int a = 1; a < 4; a++) xfer(8'(a), 24'(exp_reg[a]), 0, rx, f);
    for (int a = 3; a > 0; a--) begin
      xfer(8'h80 | 8'(a), '0, 0, rx, f);
      check("R3 R4 readback", int'(rx), exp_reg[a]);
    end

    // R2: activity with chip select high
    for (int i = 0; i < 30; i++) begin
      sdi = i[0]; sclk = ~sclk; wclk(HP);
    end
    sclk = 1'b0; wclk(4);
    xfer(8'h81, '0, 0, rx, f);
    check("R2 ignored while deselected", int'(rx), exp_reg[1]);

    // R5: reserved bits
    xfer(8'h0A, 24'h555555, 0, rx, f);
    xfer(8'h82, '0, 0, rx, f);
    check("R5 reserved write dropped", int'(rx), exp_reg[2]);
    xfer(8'h8A, '0, 0, rx, f);
    check("R5 reserved read zero", int'(rx), 0);

    // R6: abort
    partial(8'h03, 24'h0F0F0F, 20);
    xfer(8'h83, '0, 0, rx, f);
    check("R6 aborted write", int'(rx), exp_reg[3]);
    partial(8'h03, 24'h0F0F0F, 31);
    xfer(8'h83, '0, 0, rx, f);
    check("R6 abort at last bit", int'(rx), exp_reg[3]);

    // R10: three-wire back to back
    csn = 1'b0; wclk(4);
    exp_reg[4] = 24'hC0FFEE;
    xfer(8'h04, 24'(exp_reg[4]), 1, rx, f);
    xfer(8'h84, '0, 1, rx, f);
    check("R10 back-to-back read", int'(rx), exp_reg[4]);
    xfer(8'h81, '0, 1, rx, f);
    check("R10 back-to-back second", int'(rx), exp_reg[1]);
    xfer(8'h80, '0, 1, rx, f);
    check("R4 control unchanged", int'(rx), DEF_R);

    // R7: first conversion timing
    xfer(8'h00, 24'h800000 | 24'(RATIO), 1, rx, f);
    t = last_rise;
    while (sdo === 1'b1 && cyc - t < 400) wclk(1);
    diff = cyc - t;
    check("R7 first conversion window", int'(diff >= 49 && diff <= 56), 1);

    // R8: readout; sdi bits must be ignored
    xfer(8'h01, 24'hABCDEF, 1, r1v, f);
    check("R8 flag low before readout", int'(f), 0);
    diff = int'(r1v) - t;
    check("R7 first result sample time", int'(diff >= 47 && diff <= 54), 1);
    wclk(4);
    check("R9 held result flagged", int'(sdo), 0);
    xfer(8'h00, '0, 1, r2v, f);
    check("R9 R7 later result spacing",
          int'(r2v > r1v && ((int'(r2v) - int'(r1v)) % RATIO) == 0), 1);
    csn = 1'b1; wclk(6);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule